// File: doc/BRIEF.md
# Write-Masked Control Register Bank

This block holds a bank of 32-bit control words for a downstream datapath. Each word sits at a word index and is built in one of two flavours, chosen per register by a parameter bit. In the masked flavour the top half of every write carries one enable per bit of the bottom half, so software can change one field without reading the register first. In the plain flavour a write replaces the word. A field-write mode takes a value, a mask and a shift. The bank turns these into the right enables, or into a clear-and-merge of the old word, and ignores the write entirely when the mask is zero.

Writes land in a pending copy, and readback always returns that copy. The downstream logic sees a separate active copy that changes only when software sets the configuration-done bit. That bit lives in one chosen register. Setting it raises a one-cycle commit strobe, and on the next clock edge every pending word is copied into the active copy at once. A read port returns a whole pending word, and also a field of it shifted right and masked.

Top module: `wmreg_bank`

## Requirements
- R1: A synchronous active-high reset clears every pending word, every active word and the commit strobe to zero.
- R2: A whole-word write to a masked register (MASK_MAP bit set) updates pending bit i (i = 0..15) to wr_data[i] only when wr_data[16+i] is 1; other bits keep their value and bits 31..16 always read as zero.
- R3: A whole-word write (wr_field = 0) to a plain register replaces the pending word with wr_data.
- R4: A field write (wr_field = 1) to a masked register places (wr_data & fld_mask) << fld_shift in the low half, changing only the bits set in the low 16 bits of fld_mask << fld_shift.
- R5: A field write to a plain register sets the pending word to (old & ~(fld_mask << fld_shift)) | ((wr_data & fld_mask) << fld_shift).
- R6: A field write whose fld_mask is zero changes no pending word and raises no commit.
- R7: rd_data returns the pending word at rd_idx, and rd_field returns (rd_data >> rd_shift) & rd_mask, both combinationally.
- R8: Active words change only on the clock edge after commit_o is high. On that edge every active word takes its pending value. commit_o is high for the cycle that follows a write that sets the configuration-done bit.
- R9: The configuration-done bit (bit CFG_BIT of register CFG_IDX, defaults bit 0 of register 15) is never stored and reads back as zero. A write that leaves it zero, or a field write whose mask misses it, raises no commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request for this cycle |
| wr_field | input | 1 | 1: field write using fld_shift/fld_mask; 0: whole-word write |
| wr_idx | input | IDX_W (4) | Word index of the target register |
| wr_data | input | 32 | Whole word, or field value in field mode |
| fld_shift | input | 5 | Field bit position for field writes |
| fld_mask | input | 32 | Unshifted field mask for field writes |
| rd_idx | input | IDX_W (4) | Word index for readback |
| rd_shift | input | 5 | Right shift applied for rd_field |
| rd_mask | input | 32 | Mask applied after shifting for rd_field |
| rd_data | output | 32 | Pending word at rd_idx |
| rd_field | output | 32 | Shifted and masked field of the pending word |
| commit_o | output | 1 | Commit strobe; active copy loads on the next edge |
| active_o | output | NREG*32 (512) | All active words, register k in bits 32k+31..32k |

## Verification
The hardest situation to reach is the window between a configuration-done write and the commit edge. In that cycle the pending copy already holds new values, the active copy still holds old ones, and the strobe is up. The bench steps one clock at a time around the done write and samples on the falling edge, so it sees the strobe, the stale active words and then the loaded ones in order. Before that it sends done-register writes that must not commit: one with the done bit clear, and a field write whose mask misses the bit. These show that the commit is set off only by the bit itself and not by any access to its register.

// File: rtl/wmreg_pkg.sv
`timescale 1ns/1ps
package wmreg_pkg;
   localparam int WORD_W  = 32;
   localparam int HALF_W  = WORD_W / 2;
   localparam int SHIFT_W = $clog2(WORD_W);

   typedef logic [WORD_W-1:0]  word_t;
   typedef logic [HALF_W-1:0]  half_t;
   typedef logic [SHIFT_W-1:0] shamt_t;

   // value restricted to the mask, moved to the field position
   function automatic word_t place_value(word_t val, word_t msk, shamt_t sh);
      return (val & msk) << sh;
   endfunction

   // field mask moved to the field position
   function automatic word_t place_mask(word_t msk, shamt_t sh);
      return msk << sh;
   endfunction
endpackage

// File: rtl/wmreg_cell.sv
`timescale 1ns/1ps
module wmreg_cell
   import wmreg_pkg::*;
#(
   parameter bit    MASKED    = 1'b0,
   parameter word_t KEEP_ZERO = '0
) (
   input  logic   clk,
   input  logic   rst,
   input  logic   we,
   input  logic   wr_field,
   input  word_t  wr_data,
   input  word_t  fld_mask,
   input  shamt_t fld_shift,
   output logic   zero_hit,
   output word_t  value_q
);
   word_t merged;

   generate
      if (MASKED) begin : g_masked
         half_t en_h, dat_h;
         always_comb begin
            if (wr_field) begin
               en_h  = half_t'(place_mask(fld_mask, fld_shift));
               dat_h = half_t'(place_value(wr_data, fld_mask, fld_shift));
            end else begin
               en_h  = wr_data[WORD_W-1:HALF_W];
               dat_h = wr_data[HALF_W-1:0];
            end
            merged = {half_t'(0), (value_q[HALF_W-1:0] & ~en_h) | (dat_h & en_h)};
         end
      end else begin : g_plain
         word_t pm, pv;
         always_comb begin
            pm = place_mask(fld_mask, fld_shift);
            pv = place_value(wr_data, fld_mask, fld_shift);
            merged = wr_field ? ((value_q & ~pm) | pv) : wr_data;
         end
      end
   endgenerate

   assign zero_hit = we && |(merged & KEEP_ZERO);

   always_ff @(posedge clk) begin
      if (rst)     value_q <= '0;
      else if (we) value_q <= merged & ~KEEP_ZERO;
   end
endmodule

// File: rtl/wmreg_commit.sv
`timescale 1ns/1ps
module wmreg_commit
   import wmreg_pkg::*;
#(
   parameter int NREG = 16
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  load,
   input  logic [NREG-1:0][WORD_W-1:0] pend,
   output logic [NREG-1:0][WORD_W-1:0] active_q
);
   always_ff @(posedge clk) begin
      if (rst)       active_q <= '0;
      else if (load) active_q <= pend;
   end
endmodule

// File: rtl/wmreg_rdmux.sv
`timescale 1ns/1ps
module wmreg_rdmux
   import wmreg_pkg::*;
#(
   parameter int NREG  = 16,
   parameter int IDX_W = 4
) (
   input  logic [NREG-1:0][WORD_W-1:0] pend,
   input  logic [IDX_W-1:0] rd_idx,
   input  shamt_t           rd_shift,
   input  word_t            rd_mask,
   output word_t            rd_data,
   output word_t            rd_field
);
   always_comb begin
      rd_data  = pend[rd_idx];
      rd_field = (rd_data >> rd_shift) & rd_mask;
   end
endmodule

// File: rtl/wmreg_bank.sv
`timescale 1ns/1ps
module wmreg_bank
   import wmreg_pkg::*;
#(
   parameter int              NREG     = 16,
   parameter logic [NREG-1:0] MASK_MAP = 16'h00FF,
   parameter int              CFG_IDX  = 15,
   parameter int              CFG_BIT  = 0,
   localparam int             IDX_W    = $clog2(NREG)
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   wr_en,
   input  logic                   wr_field,
   input  logic [IDX_W-1:0]       wr_idx,
   input  logic [31:0]            wr_data,
   input  logic [4:0]             fld_shift,
   input  logic [31:0]            fld_mask,
   input  logic [IDX_W-1:0]       rd_idx,
   input  logic [4:0]             rd_shift,
   input  logic [31:0]            rd_mask,
   output logic [31:0]            rd_data,
   output logic [31:0]            rd_field,
   output logic                   commit_o,
   output logic [NREG*32-1:0]     active_o
);
   generate
      if (NREG < 2 || (1 << IDX_W) != NREG)
         $error("NREG must be a power of two of at least 2");
      if (CFG_IDX < 0 || CFG_IDX >= NREG)
         $error("CFG_IDX out of range");
      if (CFG_BIT < 0 || CFG_BIT >= WORD_W)
         $error("CFG_BIT out of range");
      if (MASK_MAP[CFG_IDX] && CFG_BIT >= HALF_W)
         $error("done bit must sit in the low half of a masked register");
   endgenerate

   logic [NREG-1:0][WORD_W-1:0] pend_q;
   logic [NREG-1:0][WORD_W-1:0] act_q;
   logic [NREG-1:0]             we_vec;
   logic [NREG-1:0]             hit_vec;
   logic                        fld_ok;

   assign fld_ok = !wr_field || (fld_mask != '0);

   for (genvar k = 0; k < NREG; k++) begin : g_reg
      assign we_vec[k] = wr_en && fld_ok && (wr_idx == IDX_W'(k));
      wmreg_cell #(
         .MASKED    (MASK_MAP[k]),
         .KEEP_ZERO ((k == CFG_IDX) ? (word_t'(1) << CFG_BIT) : word_t'(0))
      ) u_cell (
         .clk       (clk),
         .rst       (rst),
         .we        (we_vec[k]),
         .wr_field  (wr_field),
         .wr_data   (wr_data),
         .fld_mask  (fld_mask),
         .fld_shift (fld_shift),
         .zero_hit  (hit_vec[k]),
         .value_q   (pend_q[k])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) commit_o <= 1'b0;
      else     commit_o <= |hit_vec;
   end

   wmreg_commit #(.NREG(NREG)) u_commit (
      .clk      (clk),
      .rst      (rst),
      .load     (commit_o),
      .pend     (pend_q),
      .active_q (act_q)
   );

   assign active_o = act_q;

   wmreg_rdmux #(.NREG(NREG), .IDX_W(IDX_W)) u_rdmux (
      .pend     (pend_q),
      .rd_idx   (rd_idx),
      .rd_shift (rd_shift),
      .rd_mask  (rd_mask),
      .rd_data  (rd_data),
      .rd_field (rd_field)
   );
endmodule

// File: rtl/wmreg_bank_chk.sv
`timescale 1ns/1ps
module wmreg_bank_chk #(
   parameter int              NREG     = 16,
   parameter logic [NREG-1:0] MASK_MAP = '0,
   parameter int              CFG_IDX  = 0,
   parameter int              CFG_BIT  = 0,
   parameter int              IDX_W    = 4
) (
   input logic                        clk,
   input logic                        rst,
   input logic                        wr_en,
   input logic [IDX_W-1:0]            wr_idx,
   input logic                        commit_o,
   input logic [NREG*32-1:0]          active_o,
   input logic [NREG-1:0][31:0]       pend
);
   logic past_rst = 1'b0;
   logic armed    = 1'b0;
   always_ff @(posedge clk) begin
      past_rst <= rst;
      if (rst) armed <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (past_rst)
         AST_RESET_CLEAR: assert (active_o == '0 && pend == '0 && !commit_o); // R1
   end

   always_ff @(posedge clk) begin
      if (armed && !rst)
         AST_DONE_NOT_STORED: assert (pend[CFG_IDX][CFG_BIT] == 1'b0); // R9
   end

   for (genvar k = 0; k < NREG; k++) begin : g_upper
      if (MASK_MAP[k]) begin : g_m
         always_ff @(posedge clk) begin
            if (armed && !rst)
               AST_MASKED_UPPER_ZERO: assert (pend[k][31:16] == 16'h0); // R2
         end
      end
   end

   AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !commit_o |=> $stable(active_o)); // R8

   AST_ACTIVE_LOAD: assert property (@(posedge clk) disable iff (rst)
      commit_o |=> (active_o == $past(pend))); // R8

   AST_COMMIT_CAUSE: assert property (@(posedge clk) disable iff (rst)
      $rose(commit_o) |-> ($past(wr_en) && $past(wr_idx) == IDX_W'(CFG_IDX))); // R9
endmodule

bind wmreg_bank wmreg_bank_chk #(
   .NREG(NREG), .MASK_MAP(MASK_MAP), .CFG_IDX(CFG_IDX), .CFG_BIT(CFG_BIT), .IDX_W(IDX_W)
) u_chk (
   .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
   .commit_o(commit_o), .active_o(active_o), .pend(pend_q)
);

// File: tb/wmreg_bank_test.sv
`timescale 1ns/1ps
module wmreg_bank_test;
   localparam int NREG = 16;
   localparam logic [15:0] MMAP = 16'h00FF;
   localparam int CIDX = 15;
   localparam int CBIT = 0;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic wr_en = 1'b0, wr_field = 1'b0;
   logic [3:0] wr_idx = '0, rd_idx = '0;
   logic [31:0] wr_data = '0, fld_mask = '0, rd_mask = '0;
   logic [4:0] fld_shift = '0, rd_shift = '0;
   logic [31:0] rd_data, rd_field;
   logic commit_o;
   logic [NREG*32-1:0] active_o;

   int errors = 0, checks = 0;
   logic [31:0] mp [NREG];
   logic [31:0] ma [NREG];
   logic exp_commit = 1'b0;

   always #4 clk = ~clk;

   wmreg_bank uut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_field(wr_field), .wr_idx(wr_idx),
      .wr_data(wr_data), .fld_shift(fld_shift), .fld_mask(fld_mask),
      .rd_idx(rd_idx), .rd_shift(rd_shift), .rd_mask(rd_mask),
      .rd_data(rd_data), .rd_field(rd_field), .commit_o(commit_o), .active_o(active_o)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // expected pending value after a write, bit by bit
   task automatic model_write(input int idx, input bit fld, input logic [31:0] d,
                              input logic [31:0] m, input int sh);
      logic [31:0] nw = mp[idx];
      logic [63:0] pm = {32'h0, m} << sh;
      logic [63:0] pv = {32'h0, d & m} << sh;
      bit en;
      exp_commit = 1'b0;
      if (fld && m == 0) return;
      for (int b = 0; b < 32; b++) begin
         if (MMAP[idx]) begin
            if (b >= 16) en = 1'b0;
            else if (fld) en = pm[b];
            else en = d[16+b];
         end else begin
            en = fld ? pm[b] : 1'b1;
         end
         if (en) nw[b] = fld ? pv[b] : d[b];
      end
      if (MMAP[idx]) nw[31:16] = 16'h0;
      if (idx == CIDX && nw[CBIT]) exp_commit = 1'b1;
      if (idx == CIDX) nw[CBIT] = 1'b0;
      mp[idx] = nw;
   endtask

   task automatic do_write(input int idx, input bit fld, input logic [31:0] d,
                           input logic [31:0] m, input int sh);
      @(negedge clk);
      wr_en = 1'b1; wr_field = fld; wr_idx = 4'(idx); wr_data = d;
      fld_mask = m; fld_shift = 5'(sh);
      @(negedge clk);
      wr_en = 1'b0;
      model_write(idx, fld, d, m, sh);
   endtask

   task automatic check_pend(input int idx, input string req);
      rd_idx = 4'(idx); #1;
      chk(rd_data === mp[idx], req, rd_data, mp[idx]);
   endtask

   task automatic check_active(input string req);
      for (int k = 0; k < NREG; k++)
         chk(active_o[k*32 +: 32] === ma[k], req, active_o[k*32 +: 32], ma[k]);
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      for (int k = 0; k < NREG; k++) begin mp[k] = '0; ma[k] = '0; end
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: reset state
      for (int k = 0; k < NREG; k++) check_pend(k, "R1");
      check_active("R1");
      chk(commit_o === 1'b0, "R1", {31'h0, commit_o}, 0);

      // R3: whole-word writes to plain registers
      for (int k = 8; k < 15; k++) begin
         do_write(k, 0, 32'h1357_9BDF ^ (32'h0101_1111 * k), 0, 0);
         check_pend(k, "R3");
      end
      // R2: masked whole-word writes, full then partial enables
      for (int k = 0; k < 8; k++) begin
         do_write(k, 0, {16'hFFFF, 16'hA5C3 ^ 16'(k * 16'h1111)}, 0, 0);
         check_pend(k, "R2");
         do_write(k, 0, {16'h0F0F ^ 16'(k << 4), 16'h5A3C ^ 16'(k)}, 0, 0);
         check_pend(k, "R2");
      end
      do_write(4, 0, 32'h0000_FFFF, 0, 0);   // no enables: unchanged
      check_pend(4, "R2");
      check_active("R8");                   // nothing committed yet

      // R4: field writes into a masked register at every low-half shift
      for (int s = 0; s < 16; s++) begin
         do_write(3, 1, 32'(s) ^ 32'hFFFF_FFFE, 32'h3, s);
         check_pend(3, "R4");
      end
      // R5: field writes into a plain register at every shift
      for (int s = 0; s < 32; s++) begin
         do_write(9, 1, 32'(s * 7 + 3), 32'h1B, s);
         check_pend(9, "R5");
      end
      // R6: zero-mask field writes
      for (int s = 0; s < 32; s += 5) begin
         do_write(2, 1, 32'hFFFF_FFFF, 32'h0, s);
         check_pend(2, "R6");
         do_write(10, 1, 32'hFFFF_FFFF, 32'h0, s);
         check_pend(10, "R6");
         do_write(CIDX, 1, 32'hFFFF_FFFF, 32'h0, 0);
         chk(commit_o === 1'b0, "R6", {31'h0, commit_o}, 0);
      end

      // R7: field readback at every shift
      rd_idx = 4'd9; rd_mask = 32'hFF;
      for (int s = 0; s < 32; s++) begin
         rd_shift = 5'(s); #1;
         chk(rd_field === ((mp[9] >> s) & 32'hFF), "R7", rd_field, (mp[9] >> s) & 32'hFF);
      end
      rd_mask = 32'h0; #1;
      chk(rd_field === 32'h0, "R7", rd_field, 0);

      // R9: done register writes that must not commit
      do_write(CIDX, 0, 32'hABCD_0000, 0, 0);
      chk(commit_o === 1'b0, "R9", {31'h0, commit_o}, 0);
      check_pend(CIDX, "R9");
      do_write(CIDX, 1, 32'h0, 32'h1, 0);
      chk(commit_o === 1'b0, "R9", {31'h0, commit_o}, 0);
      do_write(CIDX, 1, 32'hF, 32'hF, 4);      // mask misses the done bit
      chk(commit_o === 1'b0, "R9", {31'h0, commit_o}, 0);
      check_pend(CIDX, "R9");
      @(negedge clk);
      check_active("R8");

      // R8/R9: committing write
      do_write(CIDX, 0, 32'h0000_1235, 0, 0);
      chk(commit_o === 1'b1 && exp_commit, "R8", {31'h0, commit_o}, 1);
      check_active("R8");                   // still old in the strobe cycle
      check_pend(CIDX, "R9");               // done bit reads zero
      @(negedge clk);
      for (int k = 0; k < NREG; k++) ma[k] = mp[k];
      check_active("R8");
      chk(commit_o === 1'b0, "R8", {31'h0, commit_o}, 0);

      // later write stays pending until a field-mode commit
      do_write(8, 0, 32'hDEAD_BEEF, 0, 0);
      check_pend(8, "R3");
      @(negedge clk);
      check_active("R8");
      do_write(CIDX, 1, 32'h1, 32'h1, 0);
      chk(commit_o === 1'b1, "R8", {31'h0, commit_o}, 1);
      @(negedge clk);
      for (int k = 0; k < NREG; k++) ma[k] = mp[k];
      check_active("R8");

      // R1: reset again after activity
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      for (int k = 0; k < NREG; k++) begin mp[k] = '0; ma[k] = '0; end
      for (int k = 0; k < NREG; k++) check_pend(k, "R1");
      check_active("R1");

      finish_run();
   end
endmodule